// File: doc/BRIEF.md
# Bridge PLL and Timing Word Calculator

This block turns a reference clock frequency in kHz and a requested serial bit rate in kbps into the setup words a display serial bridge needs. It chooses a reference pre-divider and a feedback multiplier. It works out the bit rate those two values actually give, picks the frequency band from that achieved rate, and packs the three values into one 16-bit PLL word. From the achieved rate it also derives the low-power clock divider field and the two high-speed lane delay codes (zero time and prepare time), which are packed into one 16-bit delay word.

The caller presents the operands and pulses `start` for one cycle. The block then runs for a fixed number of cycles that depends only on the chosen pre-divider. All six divisions go through one shared restoring divider that produces one quotient bit per cycle. When the last result has been captured, `done` rises. The results and `done` hold until the next accepted `start`.

Top module: `pll_word_calc`

## Requirements
- R1: A reference input of 0 kHz is treated as 2000 kHz in every calculation.
- R2: The pre-divider D starts at 1. It is incremented while the integer quotient reference/(D+1) is at least 2000, and it never exceeds 31. D appears in pllWord[12:8], and pllWord[13] is always 0.
- R3: The multiplier M is the ceiling of (rate × D) / reference. Its low 8 bits appear in pllWord[7:0].
- R4: The achieved rate A is the integer quotient (reference × M) / D. It is presented on achievedKbps.
- R5: pllWord[15:14] is 3 when A ≥ 501000, 2 when A ≥ 251000, 1 when A ≥ 126000, and 0 otherwise.
- R6: lpDivField equals (A/40000 − 1) modulo 64, so a count of zero gives 63.
- R7: With nibble period P = 1000000 / (A/4) in integer ns, delayWord[15:8] is the low byte of zeroTime/P.
- R8: delayWord[7:0] is the low byte of (prepTime − 4P)/P. When prepTime < 4P it is 0 instead of wrapping.
- R9: A zero on zeroDelayNs selects 133 ns, and a zero on prepDelayNs selects 40 ns.
- R10: `done` is low after the edge that accepts `start`. It rises exactly D + 6·(2·FREQ_W+6) + 13 rising edges after that edge. It then stays high, with every result steady, until the next accepted `start`.
- R11: A `start` pulse that arrives while a calculation is running is ignored. It changes neither the results nor the completion time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request that samples the operands |
| refKhz | input | FREQ_W | Reference clock frequency in kHz |
| rateKbps | input | FREQ_W | Requested lane bit rate in kbps |
| zeroDelayNs | input | DLY_W | HS zero time in ns (0 selects the default) |
| prepDelayNs | input | DLY_W | HS prepare time in ns (0 selects the default) |
| done | output | 1 | Results valid and held |
| pllWord | output | 16 | Band, pre-divider and multiplier packed |
| lpDivField | output | 6 | Low-power clock divider field |
| delayWord | output | 16 | Zero code in the high byte, prepare code in the low byte |
| achievedKbps | output | 2*FREQ_W+6 | Achieved bit rate in kbps |

## Verification
The latency is deterministic. The search takes D cycles, each of the six divisions takes the divider width plus two cycles, and closing the calculation takes one more cycle. For every vector the bench therefore derives the expected cycle of the rise of `done` from its own model of the pre-divider and compares the number of edges it counted. It samples on falling edges. It checks that `done` is low right after the accepting edge and reads the results only once `done` is seen high. It then waits a few more cycles to confirm that the results still hold. In the ignored-start scenario, a second pulse arrives in the middle of the run, and the bench checks both the completion edge and the values against the first operands.

// File: rtl/pll_calc_pkg.sv
package pll_calc_pkg;
  localparam int unsigned REF_FLOOR_KHZ = 2000;
  localparam int unsigned PREDIV_MAX    = 31;
  localparam int unsigned LP_RATE_STEP  = 40000;
  localparam int unsigned NS_SCALE      = 1000000;
  localparam int unsigned ZERO_DLY_DEF  = 133;
  localparam int unsigned PREP_DLY_DEF  = 40;
  localparam int unsigned BAND3_MIN     = 501000;
  localparam int unsigned BAND2_MIN     = 251000;
  localparam int unsigned BAND1_MIN     = 126000;

  // Order of the divisions; each step feeds the next.
  typedef enum logic [2:0] {
    OP_MUL  = 3'd0,
    OP_ACH  = 3'd1,
    OP_LP   = 3'd2,
    OP_NIB  = 3'd3,
    OP_ZERO = 3'd4,
    OP_PREP = 3'd5
  } divOpT;

  typedef struct packed {
    logic  loadIn;
    logic  stepSearch;
    logic  divGo;
    logic  capture;
    divOpT op;
    logic  finish;
  } ctlStrobeT;
endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int W = 46
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         busy,
  output logic         fin,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  accR;
  logic [W-1:0]  qR;
  logic [CW-1:0] cntR;
  logic [W:0]    trial;
  logic [W-1:0]  diff;
  logic          fits;

  assign trial = {accR, qR[W-1]};
  assign fits  = (trial >= {1'b0, den});
  assign diff  = trial[W-1:0] - den;
  assign quo   = qR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accR <= '0;
      qR   <= '0;
      cntR <= '0;
      busy <= 1'b0;
      fin  <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (go) begin
        accR <= '0;
        qR   <= num;
        cntR <= CW'(W);
        busy <= 1'b1;
      end else if (busy) begin
        accR <= fits ? diff : trial[W-1:0];
        qR   <= {qR[W-2:0], fits};
        cntR <= cntR - CW'(1);
        if (cntR == CW'(1)) begin
          busy <= 1'b0;
          fin  <= 1'b1;
        end
      end
    end
  end

  // Restoring step leaves a remainder below a nonzero divisor (R4).
  assert_rem_below_den_R4: assert property (@(posedge clk) disable iff (!rstN)
    fin |-> (den == '0 || accR < den));

  // Divisor must not move under a running division (R10).
  assert_den_held_R10: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !go) |=> (!busy || $stable(den)));
endmodule

// File: rtl/pll_calc_ctrl.sv
module pll_calc_ctrl
  import pll_calc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      searchMore,
  input  logic      divBusy,
  input  logic      divFin,
  output ctlStrobeT ctl
);
  typedef enum logic [2:0] {
    S_IDLE, S_SEARCH, S_LAUNCH, S_WAIT, S_FINISH
  } stateT;

  stateT stateR, stateNext;
  divOpT opR, opNext;

  always_comb begin
    ctl       = '0;
    ctl.op    = opR;
    stateNext = stateR;
    opNext    = opR;
    unique case (stateR)
      S_IDLE: begin
        if (start) begin
          ctl.loadIn = 1'b1;
          opNext     = OP_MUL;
          stateNext  = S_SEARCH;
        end
      end
      S_SEARCH: begin
        if (searchMore) ctl.stepSearch = 1'b1;
        else            stateNext      = S_LAUNCH;
      end
      S_LAUNCH: begin
        ctl.divGo = 1'b1;
        stateNext = S_WAIT;
      end
      S_WAIT: begin
        if (divFin) begin
          ctl.capture = 1'b1;
          if (opR == OP_PREP) begin
            stateNext = S_FINISH;
          end else begin
            opNext    = divOpT'(opR + 3'd1);
            stateNext = S_LAUNCH;
          end
        end
      end
      S_FINISH: begin
        ctl.finish = 1'b1;
        stateNext  = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR <= S_IDLE;
      opR    <= OP_MUL;
    end else begin
      stateR <= stateNext;
      opR    <= opNext;
    end
  end

  // The divider is only launched when it is free (R10).
  assert_go_when_free_R10: assert property (@(posedge clk) disable iff (!rstN)
    ctl.divGo |-> !divBusy);

  // Completion of a division is only expected while waiting (R11).
  assert_fin_in_wait_R11: assert property (@(posedge clk) disable iff (!rstN)
    divFin |-> (stateR == S_WAIT));
endmodule

// File: rtl/pll_calc_dp.sv
module pll_calc_dp
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 20,
  parameter int DLY_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  ctlStrobeT             ctl,
  input  logic [FREQ_W-1:0]     refKhz,
  input  logic [FREQ_W-1:0]     rateKbps,
  input  logic [DLY_W-1:0]      zeroDelayNs,
  input  logic [DLY_W-1:0]      prepDelayNs,
  output logic                  searchMore,
  output logic                  divBusy,
  output logic                  divFin,
  output logic                  done,
  output logic [15:0]           pllWord,
  output logic [5:0]            lpDivField,
  output logic [15:0]           delayWord,
  output logic [2*FREQ_W+5:0]   achievedKbps
);
  localparam int DIV_W = 2 * FREQ_W + 6;

  logic [FREQ_W-1:0] refR, rateR;
  logic [DLY_W-1:0]  zeroR, prepR;
  logic [4:0]        preDivR;
  logic [DIV_W-1:0]  thrR;
  logic [DIV_W-1:0]  mulR, achR, nibNsR;
  logic [5:0]        lpCntR;
  logic [7:0]        zeroCodeR, prepCodeR;
  logic              doneR;

  logic [DIV_W-1:0]  refExt, rateExt, divExt, zeroExt, prepExt;
  logic [DIV_W-1:0]  opNum, opDen, quo;
  logic              prepShort;
  logic [1:0]        rangeCode;

  assign refExt  = DIV_W'(refR);
  assign rateExt = DIV_W'(rateR);
  assign divExt  = DIV_W'(preDivR);
  assign zeroExt = DIV_W'(zeroR);
  assign prepExt = DIV_W'(prepR);

  assign searchMore = (preDivR < 5'(PREDIV_MAX)) && (refExt >= thrR);
  assign prepShort  = ({2'b00, prepExt} < {nibNsR, 2'b00});

  // Operand selection for the shared divider.
  always_comb begin
    opNum = '0;
    opDen = '0;
    unique case (ctl.op)
      OP_MUL: begin
        opNum = rateExt * divExt + refExt - DIV_W'(1);
        opDen = refExt;
      end
      OP_ACH: begin
        opNum = refExt * mulR;
        opDen = divExt;
      end
      OP_LP: begin
        opNum = achR;
        opDen = DIV_W'(LP_RATE_STEP);
      end
      OP_NIB: begin
        opNum = DIV_W'(NS_SCALE);
        opDen = achR >> 2;
      end
      OP_ZERO: begin
        opNum = zeroExt;
        opDen = nibNsR;
      end
      OP_PREP: begin
        opNum = prepShort ? '0 : (prepExt - (nibNsR << 2));
        opDen = nibNsR;
      end
      default: begin
        opNum = '0;
        opDen = '0;
      end
    endcase
  end

  seq_divider #(.W(DIV_W)) uDiv (
    .clk  (clk),
    .rstN (rstN),
    .go   (ctl.divGo),
    .num  (opNum),
    .den  (opDen),
    .busy (divBusy),
    .fin  (divFin),
    .quo  (quo)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refR      <= '0;
      rateR     <= '0;
      zeroR     <= '0;
      prepR     <= '0;
      preDivR   <= '0;
      thrR      <= '0;
      mulR      <= '0;
      achR      <= '0;
      nibNsR    <= '0;
      lpCntR    <= '0;
      zeroCodeR <= '0;
      prepCodeR <= '0;
      doneR     <= 1'b0;
    end else begin
      if (ctl.loadIn) begin
        refR    <= (refKhz == '0) ? FREQ_W'(REF_FLOOR_KHZ) : refKhz;
        rateR   <= rateKbps;
        zeroR   <= (zeroDelayNs == '0) ? DLY_W'(ZERO_DLY_DEF) : zeroDelayNs;
        prepR   <= (prepDelayNs == '0) ? DLY_W'(PREP_DLY_DEF) : prepDelayNs;
        preDivR <= 5'd1;
        thrR    <= DIV_W'(2 * REF_FLOOR_KHZ);
        doneR   <= 1'b0;
      end
      if (ctl.stepSearch) begin
        preDivR <= preDivR + 5'd1;
        thrR    <= thrR + DIV_W'(REF_FLOOR_KHZ);
      end
      if (ctl.capture) begin
        unique case (ctl.op)
          OP_MUL:  mulR      <= quo;
          OP_ACH:  achR      <= quo;
          OP_LP:   lpCntR    <= quo[5:0];
          OP_NIB:  nibNsR    <= quo;
          OP_ZERO: zeroCodeR <= quo[7:0];
          OP_PREP: prepCodeR <= quo[7:0];
          default: ;
        endcase
      end
      if (ctl.finish) doneR <= 1'b1;
    end
  end

  always_comb begin
    if      (achR >= DIV_W'(BAND3_MIN)) rangeCode = 2'd3;
    else if (achR >= DIV_W'(BAND2_MIN)) rangeCode = 2'd2;
    else if (achR >= DIV_W'(BAND1_MIN)) rangeCode = 2'd1;
    else                                rangeCode = 2'd0;
  end

  assign done         = doneR;
  assign pllWord      = {rangeCode, 1'b0, preDivR, mulR[7:0]};
  assign lpDivField   = lpCntR - 6'd1;
  assign delayWord    = {zeroCodeR, prepCodeR};
  assign achievedKbps = achR;

  assert_prediv_bounds_R2: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (preDivR >= 5'd1 && preDivR <= 5'(PREDIV_MAX)));

  assert_ref_nonzero_R1: assert property (@(posedge clk) disable iff (!rstN)
    ctl.divGo |-> (refR != '0));

  assert_prep_saturates_R8: assert property (@(posedge clk) disable iff (!rstN)
    (done && prepShort) |-> (prepCodeR == 8'd0));

  assert_results_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (done && !ctl.loadIn) |=> ($stable(pllWord) && $stable(delayWord)
                               && $stable(lpDivField) && done));
endmodule

// File: rtl/pll_word_calc.sv
module pll_word_calc
  import pll_calc_pkg::*;
#(
  parameter int FREQ_W = 20,
  parameter int DLY_W  = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [FREQ_W-1:0]   refKhz,
  input  logic [FREQ_W-1:0]   rateKbps,
  input  logic [DLY_W-1:0]    zeroDelayNs,
  input  logic [DLY_W-1:0]    prepDelayNs,
  output logic                done,
  output logic [15:0]         pllWord,
  output logic [5:0]          lpDivField,
  output logic [15:0]         delayWord,
  output logic [2*FREQ_W+5:0] achievedKbps
);
  ctlStrobeT ctl;
  logic      searchMore, divBusy, divFin;

  pll_calc_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .searchMore (searchMore),
    .divBusy    (divBusy),
    .divFin     (divFin),
    .ctl        (ctl)
  );

  pll_calc_dp #(.FREQ_W(FREQ_W), .DLY_W(DLY_W)) uDp (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .refKhz       (refKhz),
    .rateKbps     (rateKbps),
    .zeroDelayNs  (zeroDelayNs),
    .prepDelayNs  (prepDelayNs),
    .searchMore   (searchMore),
    .divBusy      (divBusy),
    .divFin       (divFin),
    .done         (done),
    .pllWord      (pllWord),
    .lpDivField   (lpDivField),
    .delayWord    (delayWord),
    .achievedKbps (achievedKbps)
  );
endmodule

// File: tb/tb_pll_word_calc.sv
module tb_pll_word_calc;
  localparam int FREQ_W = 20;
  localparam int DLY_W  = 16;
  localparam int DIV_W  = 2 * FREQ_W + 6;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [FREQ_W-1:0] refKhz = '0;
  logic [FREQ_W-1:0] rateKbps = '0;
  logic [DLY_W-1:0]  zeroDelayNs = '0;
  logic [DLY_W-1:0]  prepDelayNs = '0;
  logic              done;
  logic [15:0]       pllWord;
  logic [5:0]        lpDivField;
  logic [15:0]       delayWord;
  logic [DIV_W-1:0]  achievedKbps;

  int vectors = 0;
  int fails = 0;

  always #10 clk = ~clk;

  pll_word_calc #(.FREQ_W(FREQ_W), .DLY_W(DLY_W)) dut (
    .clk(clk), .rstN(rstN), .start(start), .refKhz(refKhz),
    .rateKbps(rateKbps), .zeroDelayNs(zeroDelayNs), .prepDelayNs(prepDelayNs),
    .done(done), .pllWord(pllWord), .lpDivField(lpDivField),
    .delayWord(delayWord), .achievedKbps(achievedKbps)
  );

  task automatic checkVal(input string req, input string what,
                          input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Model of the requirements.
  task automatic model(input longint refIn, rate, zIn, pIn,
                       output longint d, pll, ach, lp, dly);
    longint r, m, band, nf, np, z, p, zc, pc;
    r = (refIn == 0) ? 2000 : refIn;                        // R1
    d = 1;
    while (r / (d + 1) >= 2000) d++;                        // R2
    if (d > 31) d = 31;
    m = (rate * d + r - 1) / r;                             // R3
    ach = r * m / d;                                        // R4
    if (ach >= 501000) band = 3;                            // R5
    else if (ach >= 251000) band = 2;
    else if (ach >= 126000) band = 1;
    else band = 0;
    pll = (band << 14) | (d << 8) | (m & 255);
    lp = ((ach / 40000) - 1) & 63;                          // R6
    nf = ach / 4;
    np = 1000000 / nf;
    z = (zIn == 0) ? 133 : zIn;                             // R9
    p = (pIn == 0) ? 40 : pIn;
    zc = (z / np) & 255;                                    // R7
    pc = (p < 4 * np) ? 0 : ((p - 4 * np) / np) & 255;      // R8
    dly = (zc << 8) | pc;
  endtask

  task automatic waitDone(output int lat);
    lat = 0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic checkResults(input longint d, pll, ach, lp, dly);
    checkVal("R2", "pre-divider field", longint'(pllWord[12:8]), (pll >> 8) & 31);
    checkVal("R2", "bit 13", longint'(pllWord[13]), 0);
    checkVal("R3", "multiplier field", longint'(pllWord[7:0]), pll & 255);
    checkVal("R5", "band field", longint'(pllWord[15:14]), (pll >> 14) & 3);
    checkVal("R4", "achieved rate", longint'(achievedKbps), ach);
    checkVal("R6", "low-power divider", longint'(lpDivField), lp);
    checkVal("R7", "zero code", longint'(delayWord[15:8]), (dly >> 8) & 255);
    checkVal("R8", "prepare code", longint'(delayWord[7:0]), dly & 255);
  endtask

  task automatic runCase(input string tag, input longint refIn, rate, zIn, pIn);
    longint d, pll, ach, lp, dly;
    int lat;
    logic [15:0] pllSnap;
    model(refIn, rate, zIn, pIn, d, pll, ach, lp, dly);
    @(negedge clk);
    refKhz = FREQ_W'(refIn);
    rateKbps = FREQ_W'(rate);
    zeroDelayNs = DLY_W'(zIn);
    prepDelayNs = DLY_W'(pIn);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    checkVal("R10", {tag, " done cleared"}, longint'(done), 0);
    waitDone(lat);
    checkVal("R10", {tag, " latency"}, lat, d + 6 * DIV_W + 13);
    checkResults(d, pll, ach, lp, dly);
    pllSnap = pllWord;
    repeat (3) @(negedge clk);
    checkVal("R10", {tag, " done held"}, longint'(done), 1);
    checkVal("R10", {tag, " word held"}, longint'(pllWord), longint'(pllSnap));
  endtask

  // R11: second start mid-run must not disturb the first calculation.
  task automatic runIgnoredStart();
    longint d, pll, ach, lp, dly;
    int lat;
    model(19200, 450000, 150, 90, d, pll, ach, lp, dly);
    @(negedge clk);
    refKhz = 20'd19200;
    rateKbps = 20'd450000;
    zeroDelayNs = 16'd150;
    prepDelayNs = 16'd90;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    repeat (40) begin
      @(negedge clk);
      lat++;
    end
    refKhz = 20'd50000;
    rateKbps = 20'd120000;
    zeroDelayNs = 16'd999;
    prepDelayNs = 16'd777;
    start = 1'b1;
    @(negedge clk);
    lat++;
    start = 1'b0;
    while (!done && lat < 1000) begin
      @(negedge clk);
      lat++;
    end
    checkVal("R11", "latency unchanged", lat, d + 6 * DIV_W + 13);
    checkVal("R11", "word from first operands", longint'(pllWord), pll);
    checkVal("R11", "delay from first operands", longint'(delayWord), dly);
    checkVal("R11", "rate from first operands", longint'(achievedKbps), ach);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checkVal("R10", "reset done", longint'(done), 0);
    checkVal("R5", "reset pll word", longint'(pllWord), 0);
    checkVal("R8", "reset delay word", longint'(delayWord), 0);
    rstN = 1'b1;
    @(negedge clk);

    runCase("R9 defaults", 19200, 432000, 0, 0);
    runCase("R1 zero ref", 0, 300000, 200, 150);
    runCase("R2 clamp", 100000, 800000, 0, 0);
    runCase("R5 band3 edge", 1000, 501000, 0, 0);
    runCase("R5 band2 top", 1000, 500000, 0, 0);
    runCase("R5 band2 edge", 1000, 251000, 0, 0);
    runCase("R5 band1 top", 1000, 250000, 0, 0);
    runCase("R5 band1 edge", 1000, 126000, 0, 0);
    runCase("R5 band0 top", 1000, 125000, 0, 0);
    runCase("R6 R8 low rate", 2000, 30000, 0, 0);
    runCase("R7 R8 explicit", 27000, 600000, 500, 300);
    runCase("R3 rounding", 26000, 333333, 0, 0);
    runIgnoredStart();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule